// File: doc/BRIEF.md
# Speculative Load Bypass and Forwarding Queue

This block sits beside the load/store path of an out-of-order core and tracks stores that are still in flight. A store is allocated in program order, and its address and its data arrive later and independently. Each new load is answered in the same cycle with one decision. The load can read the cache, take its value from the youngest older store that writes the same address, or stall. A load may run even when some older stores have not yet produced an address. Such a speculative load is remembered. When one of those stores later resolves to the load's address, the block raises a replay with the load's tag.

Loads are assumed to be presented in program order relative to store allocation, so every valid store is older than the load being asked about. Addresses are compared as whole words, with no partial overlap. Retirement releases the oldest store through a single strobe and is driven from outside.

Top module: `sq_bypass_fwd_unit`

## Requirements
- R1: Stores are allocated at the tail index shown on `st_alloc_idx_o`, which starts at 0 after reset and advances by one (wrapping) per accepted allocation. When DEPTH stores are held, `st_full_o` is 1 and further allocations are ignored.
- R2: The address and the data of a store are written by index through separate ports, in either order. A store whose address is still unknown never supplies forwarded data, even when its data is known.
- R3: When no valid store has a known address equal to the load address, the load is answered with source CACHE (code 1), even if some stores still have unknown addresses.
- R4: When stores with a known matching address exist, the youngest of them is chosen. If its data is known, the source is FORWARD (code 2) and `ld_data_o` carries that data. Otherwise `ld_data_o` is 0.
- R5: When the youngest matching store has no data yet, the source is WAIT (code 3). Once the data is written, the next request for the same load is answered FORWARD.
- R6: A load answered CACHE or FORWARD while younger-than-the-source stores have unknown addresses is recorded. If one of those stores later resolves to the load's address, `replay_o` is 1 with the load's tag on `replay_tag_o` in the cycle after the resolve. If it resolves to another address, no replay follows.
- R7: Stores with unknown addresses that are older than the store a load forwards from never cause a replay for that load.
- R8: When a load would need recording and all SLOTS tracking entries are busy, the source is WAIT and nothing is recorded.
- R9: Several conflicting loads are reported one per cycle, lowest tracking entry first. Each report lasts one cycle, and `replay_o` returns to 0 once all are reported.
- R10: `st_release_i` frees the oldest store. After that, the store no longer matches loads and its slot can be allocated again.
- R11: Without a load request, the source is NONE (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_alloc_i | input | 1 | Allocate a store at the tail |
| st_alloc_idx_o | output | $clog2(DEPTH) | Index the next allocation receives |
| st_full_o | output | 1 | Queue holds DEPTH stores |
| st_addr_we_i | input | 1 | Resolve a store address |
| st_addr_idx_i | input | $clog2(DEPTH) | Store index for the address write |
| st_addr_i | input | AW | Resolved store address |
| st_data_we_i | input | 1 | Resolve store data |
| st_data_idx_i | input | $clog2(DEPTH) | Store index for the data write |
| st_data_i | input | DW | Resolved store data |
| st_release_i | input | 1 | Release the oldest store |
| ld_req_i | input | 1 | Load request valid |
| ld_addr_i | input | AW | Load address |
| ld_tag_i | input | TW | Load tag |
| ld_src_o | output | 2 | 0 none, 1 cache, 2 forward, 3 wait |
| ld_data_o | output | DW | Forwarded data, 0 unless forwarding |
| replay_o | output | 1 | A recorded load must replay |
| replay_tag_o | output | TW | Tag of the load to replay |

## Verification
Loads are issued against several store layouts. In one, only a known store matches. In another, nothing matches while addresses are still unknown. A third has a match whose data is missing, and a fourth has an unknown store older than the match. Together these separate the cache, forward and wait paths and show which unknown stores are tracked. Late address resolves are tried both with the load's address and with another address, so a real conflict is distinguished from a harmless resolve. A burst of four conflicting loads fills the tracking table. It shows the stall on a full table and the one-per-cycle, lowest-first replay order. Wrap-around, full-queue allocation, release and data-before-address resolution are covered at the end.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_CACHE = 2'd1,
        LD_FWD   = 2'd2,
        LD_WAIT  = 2'd3
    } ld_src_e;

    // Index of the slot that is k positions younger than the head.
    function automatic int unsigned ring_pos(int unsigned head, int unsigned k,
                                             int unsigned depth);
        return (head + k) % depth;
    endfunction

    function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
        return (p + 1) % depth;
    endfunction

endpackage

// File: rtl/sq_store_array.sv
module sq_store_array #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_i,
    input  logic                       addr_we_i,
    input  logic [IW-1:0]              addr_idx_i,
    input  logic [AW-1:0]              addr_i,
    input  logic                       data_we_i,
    input  logic [IW-1:0]              data_idx_i,
    input  logic [DW-1:0]              data_i,
    input  logic                       release_i,
    output logic [DEPTH-1:0]           vld_o,
    output logic [DEPTH-1:0]           a_ok_o,
    output logic [DEPTH-1:0]           d_ok_o,
    output logic [DEPTH-1:0][AW-1:0]   addr_o,
    output logic [DEPTH-1:0][DW-1:0]   data_o,
    output logic [IW-1:0]              head_o,
    output logic [IW-1:0]              tail_o,
    output logic                       full_o
);
    import sq_pkg::*;

    logic [DEPTH-1:0]         vld, a_ok, d_ok;
    logic [DEPTH-1:0][AW-1:0] addr;
    logic [DEPTH-1:0][DW-1:0] data;
    logic [IW-1:0]            head, tail;
    logic [CW-1:0]            cnt;
    logic                     alloc_go, rel_go;

    assign full_o   = (cnt == CW'(DEPTH));
    assign alloc_go = alloc_i && !full_o;
    assign rel_go   = release_i && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            a_ok <= '0;
            d_ok <= '0;
            addr <= '0;
            data <= '0;
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (alloc_go) begin
                vld[tail]  <= 1'b1;
                a_ok[tail] <= 1'b0;
                d_ok[tail] <= 1'b0;
                tail       <= IW'(ring_next(int'(tail), DEPTH));
            end
            if (addr_we_i && vld[addr_idx_i]) begin
                a_ok[addr_idx_i] <= 1'b1;
                addr[addr_idx_i] <= addr_i;
            end
            if (data_we_i && vld[data_idx_i]) begin
                d_ok[data_idx_i] <= 1'b1;
                data[data_idx_i] <= data_i;
            end
            if (rel_go) begin
                vld[head] <= 1'b0;
                head      <= IW'(ring_next(int'(head), DEPTH));
            end
            cnt <= cnt + CW'(alloc_go) - CW'(rel_go);
        end
    end

    assign vld_o  = vld;
    assign a_ok_o = a_ok;
    assign d_ok_o = d_ok;
    assign addr_o = addr;
    assign data_o = data;
    assign head_o = head;
    assign tail_o = tail;

endmodule

// File: rtl/sq_load_search.sv
module sq_load_search #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         vld_i,
    input  logic [DEPTH-1:0]         a_ok_i,
    input  logic [DEPTH-1:0][AW-1:0] addr_i,
    input  logic [IW-1:0]            head_i,
    input  logic [AW-1:0]            ld_addr_i,
    output logic                     hit_o,
    output logic [IW-1:0]            hit_idx_o,
    output logic [DEPTH-1:0]         spec_mask_o
);
    import sq_pkg::*;

    int unsigned hit_age;

    // Walk from oldest to youngest; the last match wins, giving the youngest.
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        hit_age   = 0;
        for (int k = 0; k < DEPTH; k++) begin
            int unsigned j;
            j = ring_pos(int'(head_i), k, DEPTH);
            if (vld_i[j] && a_ok_i[j] && (addr_i[j] == ld_addr_i)) begin
                hit_o     = 1'b1;
                hit_idx_o = IW'(j);
                hit_age   = k;
            end
        end
    end

    // Unknown-address stores younger than the source could still alias.
    always_comb begin
        spec_mask_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int unsigned j;
            j = ring_pos(int'(head_i), k, DEPTH);
            if (vld_i[j] && !a_ok_i[j] && (!hit_o || k > hit_age))
                spec_mask_o[j] = 1'b1;
        end
    end

endmodule

// File: rtl/sq_spec_tracker.sv
module sq_spec_tracker #(
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    parameter int AW    = 32,
    parameter int TW    = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec_i,
    input  logic [AW-1:0]    rec_addr_i,
    input  logic [TW-1:0]    rec_tag_i,
    input  logic [DEPTH-1:0] rec_mask_i,
    input  logic             res_we_i,
    input  logic [IW-1:0]    res_idx_i,
    input  logic [AW-1:0]    res_addr_i,
    output logic             full_o,
    output logic             replay_o,
    output logic [TW-1:0]    replay_tag_o
);
    logic [SLOTS-1:0]           busy, conf;
    logic [SLOTS-1:0][TW-1:0]   tags;
    logic [DEPTH-1:0]           res_bit, rec_rest;
    logic                       rec_hit, rec_keep;
    logic                       free_found, pick_found;
    logic [SW-1:0]              free_sel, pick_sel;

    assign res_bit  = res_we_i ? (DEPTH'(1) << res_idx_i) : '0;
    assign rec_hit  = |(rec_mask_i & res_bit) && (rec_addr_i == res_addr_i);
    assign rec_rest = rec_mask_i & ~res_bit;
    assign rec_keep = rec_i && free_found && (rec_hit || (rec_rest != '0));

    // Lowest free entry and lowest conflicted entry.
    always_comb begin
        free_found = 1'b0;
        free_sel   = '0;
        pick_found = 1'b0;
        pick_sel   = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!busy[s]) begin
                free_found = 1'b1;
                free_sel   = SW'(s);
            end
            if (busy[s] && conf[s]) begin
                pick_found = 1'b1;
                pick_sel   = SW'(s);
            end
        end
    end

    assign full_o       = &busy;
    assign replay_o     = pick_found;
    assign replay_tag_o = tags[pick_sel];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic             b_q, c_q;
        logic [DEPTH-1:0] m_q, m_left;
        logic [AW-1:0]    a_q;
        logic [TW-1:0]    t_q;

        assign m_left = m_q & ~res_bit;

        always_ff @(posedge clk) begin
            if (rst) begin
                b_q <= 1'b0;
                c_q <= 1'b0;
                m_q <= '0;
                a_q <= '0;
                t_q <= '0;
            end else if (rec_keep && (free_sel == SW'(s))) begin
                b_q <= 1'b1;
                c_q <= rec_hit;
                m_q <= rec_rest;
                a_q <= rec_addr_i;
                t_q <= rec_tag_i;
            end else if (b_q) begin
                if (c_q) begin
                    if (pick_found && (pick_sel == SW'(s))) begin
                        b_q <= 1'b0;
                        c_q <= 1'b0;
                    end
                end else if ((m_q & res_bit) != '0) begin
                    if (a_q == res_addr_i) begin
                        c_q <= 1'b1;
                    end else begin
                        m_q <= m_left;
                        if (m_left == '0) b_q <= 1'b0;
                    end
                end
            end
        end

        assign busy[s] = b_q;
        assign conf[s] = c_q;
        assign tags[s] = t_q;
    end

endmodule

// File: rtl/sq_bypass_fwd_unit.sv
module sq_bypass_fwd_unit #(
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int TW    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_alloc_i,
    output logic [IW-1:0] st_alloc_idx_o,
    output logic          st_full_o,
    input  logic          st_addr_we_i,
    input  logic [IW-1:0] st_addr_idx_i,
    input  logic [AW-1:0] st_addr_i,
    input  logic          st_data_we_i,
    input  logic [IW-1:0] st_data_idx_i,
    input  logic [DW-1:0] st_data_i,
    input  logic          st_release_i,
    input  logic          ld_req_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic [TW-1:0] ld_tag_i,
    output logic [1:0]    ld_src_o,
    output logic [DW-1:0] ld_data_o,
    output logic          replay_o,
    output logic [TW-1:0] replay_tag_o
);
    import sq_pkg::*;

    logic [DEPTH-1:0]         vld, a_ok, d_ok, spec_mask;
    logic [DEPTH-1:0][AW-1:0] st_addr;
    logic [DEPTH-1:0][DW-1:0] st_data;
    logic [IW-1:0]            head, tail, hit_idx;
    logic                     hit, trk_full, spec, record;
    ld_src_e                  src;

    sq_store_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .alloc_i   (st_alloc_i),
        .addr_we_i (st_addr_we_i),
        .addr_idx_i(st_addr_idx_i),
        .addr_i    (st_addr_i),
        .data_we_i (st_data_we_i),
        .data_idx_i(st_data_idx_i),
        .data_i    (st_data_i),
        .release_i (st_release_i),
        .vld_o     (vld),
        .a_ok_o    (a_ok),
        .d_ok_o    (d_ok),
        .addr_o    (st_addr),
        .data_o    (st_data),
        .head_o    (head),
        .tail_o    (tail),
        .full_o    (st_full_o)
    );

    sq_load_search #(.DEPTH(DEPTH), .AW(AW)) u_search (
        .vld_i      (vld),
        .a_ok_i     (a_ok),
        .addr_i     (st_addr),
        .head_i     (head),
        .ld_addr_i  (ld_addr_i),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .spec_mask_o(spec_mask)
    );

    assign spec = (spec_mask != '0);

    always_comb begin
        if (!ld_req_i)                src = LD_NONE;
        else if (hit && !d_ok[hit_idx]) src = LD_WAIT;
        else if (spec && trk_full)    src = LD_WAIT;
        else if (hit)                 src = LD_FWD;
        else                          src = LD_CACHE;
    end

    assign record    = spec && ((src == LD_FWD) || (src == LD_CACHE));
    assign ld_src_o  = src;
    assign ld_data_o = (src == LD_FWD) ? st_data[hit_idx] : '0;
    assign st_alloc_idx_o = tail;

    sq_spec_tracker #(.DEPTH(DEPTH), .SLOTS(SLOTS), .AW(AW), .TW(TW)) u_track (
        .clk         (clk),
        .rst         (rst),
        .rec_i       (record),
        .rec_addr_i  (ld_addr_i),
        .rec_tag_i   (ld_tag_i),
        .rec_mask_i  (spec_mask),
        .res_we_i    (st_addr_we_i),
        .res_idx_i   (st_addr_idx_i),
        .res_addr_i  (st_addr_i),
        .full_o      (trk_full),
        .replay_o    (replay_o),
        .replay_tag_o(replay_tag_o)
    );

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          st_alloc_i,
    input logic          st_release_i,
    input logic          st_addr_we_i,
    input logic [IW-1:0] st_alloc_idx_o,
    input logic          st_full_o,
    input logic          ld_req_i,
    input logic [1:0]    ld_src_o,
    input logic [DW-1:0] ld_data_o,
    input logic          replay_o
);
    // R1: a full queue ignores allocation
    a_r1_full_holds: assert property (@(posedge clk) disable iff (rst)
        (st_full_o && st_alloc_i && !st_release_i) |=> st_full_o);

    // R1: an accepted allocation moves the tail
    a_r1_tail_moves: assert property (@(posedge clk) disable iff (rst)
        (st_alloc_i && !st_full_o) |=> (st_alloc_idx_o != $past(st_alloc_idx_o)));

    // R11: no request gives no source
    a_r11_idle_none: assert property (@(posedge clk) disable iff (rst)
        !ld_req_i |-> (ld_src_o == 2'd0));

    // R6: a replay only starts after an address resolve
    a_r6_replay_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(replay_o) |-> $past(st_addr_we_i));

    // R4: data lines stay quiet unless forwarding
    a_r4_data_quiet: assert property (@(posedge clk) disable iff (rst)
        (ld_src_o != 2'd2) |-> (ld_data_o == '0));
endmodule

bind sq_bypass_fwd_unit sq_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_alloc_i    (st_alloc_i),
    .st_release_i  (st_release_i),
    .st_addr_we_i  (st_addr_we_i),
    .st_alloc_idx_o(st_alloc_idx_o),
    .st_full_o     (st_full_o),
    .ld_req_i      (ld_req_i),
    .ld_src_o      (ld_src_o),
    .ld_data_o     (ld_data_o),
    .replay_o      (replay_o)
);

// File: tb/tb_sq_bypass_fwd_unit.sv
module tb_sq_bypass_fwd_unit;
    localparam int DEPTH = 8;
    localparam int SLOTS = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int TW    = 4;
    localparam int IW    = $clog2(DEPTH);

    localparam int K_LOAD = 0, K_REPLAY = 1, K_FULL = 2, K_IDX = 3;
    localparam int S_NONE = 0, S_CACHE = 1, S_FWD = 2, S_WAIT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          st_alloc_i = 0, st_addr_we_i = 0, st_data_we_i = 0, st_release_i = 0;
    logic [IW-1:0] st_addr_idx_i = '0, st_data_idx_i = '0, st_alloc_idx_o;
    logic [AW-1:0] st_addr_i = '0, ld_addr_i = '0;
    logic [DW-1:0] st_data_i = '0, ld_data_o;
    logic          st_full_o, ld_req_i = 0, replay_o;
    logic [TW-1:0] ld_tag_i = '0, replay_tag_o;
    logic [1:0]    ld_src_o;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        int    cyc;
        int    kind;
        int    a;
        int    b;
        string req;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sq_bypass_fwd_unit #(.DEPTH(DEPTH), .SLOTS(SLOTS), .AW(AW), .DW(DW), .TW(TW)) dut (
        .clk(clk), .rst(rst),
        .st_alloc_i(st_alloc_i), .st_alloc_idx_o(st_alloc_idx_o), .st_full_o(st_full_o),
        .st_addr_we_i(st_addr_we_i), .st_addr_idx_i(st_addr_idx_i), .st_addr_i(st_addr_i),
        .st_data_we_i(st_data_we_i), .st_data_idx_i(st_data_idx_i), .st_data_i(st_data_i),
        .st_release_i(st_release_i),
        .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i), .ld_tag_i(ld_tag_i),
        .ld_src_o(ld_src_o), .ld_data_o(ld_data_o),
        .replay_o(replay_o), .replay_tag_o(replay_tag_o)
    );

    // Monitor: compare items due in this cycle, mid-cycle.
    always @(negedge clk) begin
        if (!rst) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                int   act_a, act_b;
                e = q.pop_front();
                act_b = 0;
                case (e.kind)
                    K_LOAD:   begin act_a = int'(ld_src_o); act_b = int'(ld_data_o); end
                    K_REPLAY: begin act_a = int'(replay_o);
                                    act_b = replay_o ? int'(replay_tag_o) : 0; end
                    K_FULL:   act_a = int'(st_full_o);
                    default:  act_a = int'(st_alloc_idx_o);
                endcase
                checks++;
                if (act_a != e.a || act_b != e.b) begin
                    errors++;
                    $display("FAIL %s kind %0d cycle %0d: actual %0d/%0h expected %0d/%0h",
                             e.req, e.kind, cyc, act_a, act_b, e.a, e.b);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        st_alloc_i   = 0;
        st_addr_we_i = 0;
        st_data_we_i = 0;
        st_release_i = 0;
        ld_req_i     = 0;
    endtask

    task automatic expect_at(int delay, int kind, int a, int b, string req);
        exp_t e;
        e.cyc = cyc + delay; e.kind = kind; e.a = a; e.b = b; e.req = req;
        q.push_back(e);
    endtask

    task automatic do_alloc();
        st_alloc_i = 1;
    endtask

    task automatic do_addr(int idx, int a);
        st_addr_we_i = 1; st_addr_idx_i = IW'(idx); st_addr_i = AW'(a);
    endtask

    task automatic do_data(int idx, int d);
        st_data_we_i = 1; st_data_idx_i = IW'(idx); st_data_i = DW'(d);
    endtask

    task automatic do_load(int a, int tag);
        ld_req_i = 1; ld_addr_i = AW'(a); ld_tag_i = TW'(tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // Reset state
        expect_at(0, K_IDX, 0, 0, "R1 reset idx");
        expect_at(0, K_FULL, 0, 0, "R1 reset full");
        expect_at(0, K_REPLAY, 0, 0, "R6 reset replay");
        expect_at(0, K_LOAD, S_NONE, 0, "R11 reset src");

        tick(); do_alloc(); expect_at(0, K_IDX, 0, 0, "R1 alloc s0");
        tick(); do_alloc(); do_addr(0, 'h100); expect_at(0, K_IDX, 1, 0, "R1 alloc s1");
        tick(); do_alloc(); do_data(0, 'hAAAA); expect_at(0, K_IDX, 2, 0, "R1 alloc s2");
        // s0 known 0x100, s1/s2 unknown
        tick(); do_load('h100, 1); expect_at(0, K_LOAD, S_FWD, 'hAAAA, "R4 forward past unknowns");
        tick(); do_load('h200, 2); expect_at(0, K_LOAD, S_CACHE, 0, "R3 bypass unknowns");
        tick(); do_addr(1, 'h300); expect_at(1, K_REPLAY, 0, 0, "R6 non-matching resolve");
        tick(); do_addr(2, 'h200); expect_at(1, K_REPLAY, 1, 2, "R6 matching resolve tag2");
        tick(); do_load('h200, 3); expect_at(0, K_LOAD, S_WAIT, 0, "R5 data missing");
        tick(); do_data(2, 'hBBBB); do_load('h200, 3);
        expect_at(0, K_LOAD, S_WAIT, 0, "R5 data landing this cycle");
        expect_at(0, K_REPLAY, 0, 0, "R9 single replay ends");
        tick(); do_load('h200, 3); expect_at(0, K_LOAD, S_FWD, 'hBBBB, "R5 forward after data");
        tick(); st_release_i = 1;
        tick(); st_release_i = 1; do_load('h100, 4);
        expect_at(0, K_LOAD, S_CACHE, 0, "R10 released store gone");
        tick(); do_alloc(); expect_at(0, K_IDX, 3, 0, "R1 alloc s3");
        tick(); do_alloc(); expect_at(0, K_IDX, 4, 0, "R1 alloc s4");
        tick(); do_addr(4, 'h400); do_data(4, 'h4444);
        tick(); do_load('h400, 5); expect_at(0, K_LOAD, S_FWD, 'h4444, "R4 youngest match");
        tick(); do_addr(3, 'h400); expect_at(1, K_REPLAY, 0, 0, "R7 older unknown no replay");
        tick(); do_alloc(); expect_at(0, K_IDX, 5, 0, "R1 alloc s5");
        for (int t = 6; t <= 9; t++) begin
            tick(); do_load('h500, t);
            expect_at(0, K_LOAD, S_CACHE, 0, "R6 speculative cache load");
        end
        tick(); do_load('h600, 10); expect_at(0, K_LOAD, S_WAIT, 0, "R8 table full");
        tick(); do_addr(5, 'h500);
        for (int t = 6; t <= 9; t++)
            expect_at(t - 5, K_REPLAY, 1, t, "R9 ordered replay");
        expect_at(5, K_REPLAY, 0, 0, "R9 replays drained");
        repeat (5) tick();
        do_alloc(); expect_at(0, K_IDX, 6, 0, "R1 alloc s6");
        tick(); do_alloc(); do_data(6, 'h6666); expect_at(0, K_IDX, 7, 0, "R1 alloc s7");
        tick(); do_alloc(); do_load('h700, 11);
        expect_at(0, K_IDX, 0, 0, "R1 wrap idx");
        expect_at(0, K_LOAD, S_CACHE, 0, "R2 data-only store not forwarded");
        tick(); do_alloc(); do_addr(6, 'h700);
        expect_at(0, K_IDX, 1, 0, "R1 alloc s1 again");
        expect_at(1, K_REPLAY, 1, 11, "R6 replay tag11");
        tick(); do_alloc();
        expect_at(0, K_FULL, 1, 0, "R1 full");
        expect_at(0, K_IDX, 2, 0, "R1 idx at full");
        tick(); do_load('h700, 12);
        expect_at(0, K_FULL, 1, 0, "R1 alloc ignored when full");
        expect_at(0, K_IDX, 2, 0, "R1 idx unchanged when full");
        expect_at(0, K_LOAD, S_FWD, 'h6666, "R2 forward after late address");
        expect_at(0, K_REPLAY, 0, 0, "R9 replay cleared");
        tick(); st_release_i = 1;
        tick();
        expect_at(0, K_FULL, 0, 0, "R10 release clears full");
        expect_at(0, K_LOAD, S_NONE, 0, "R11 idle");
        repeat (3) tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule